// File: doc/BRIEF.md
# Center-Spread Modulation Profile Generator

This block runs on the reference clock and produces a signed frequency-offset word for a fractional feedback divider downstream. While spreading is on, the word traces a symmetric triangle around zero. Every sweep lasts the same fixed number of reference cycles. The downstream loop turns the word into a clock whose frequency moves equally above and below its nominal value, which spreads the clock's energy over a band.

The sweep amplitude comes from a table. Two select inputs each carry the decoded state of a three-level pin (Low, Middle or High). A band index names the input-frequency slot the reference falls in. A new selection takes effect only at the start of a period, so a sweep that is already running is never reshaped. An enable input switches spreading off at once. Turning it back on restarts the sweep at its lowest point. A selection that the chosen frequency range does not support raises an error flag and holds the offset at zero.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released with the enable low, `offset_o` is 0 and `cfg_err_o` is 0.
- R2: While enabled, the offset sequence repeats every 2332 clock cycles, and each period starts at its lowest point.
- R3: Let p be the position within the period (0..2331), H the half amplitude, q = p for p ≤ 1166 and q = 2332 − p otherwise. The offset at position p is −H + floor(2·H·q / 1166). Position 0 is the first rising clock edge on which the period is loaded.
- R4: The sweep is centered. At position 1166 the offset is +H, at position 0 it is −H, and it never leaves the range [−H, +H].
- R5: If the enable is sampled low at a clock edge, the offset is 0 after that edge and the position resets. The first edge on which the enable is sampled high again loads a new period at position 0, which gives an offset of −H.
- R6: Each select input uses 2'b00 for Low, 2'b01 for Middle, 2'b10 for High, and 2'b11 is reserved. Band indices 0..3 form the low range and 4..12 the high range. The codes (sel_a, sel_b), ordered from largest spread to smallest, are: low range M/M, M/L, H/L, L/L, L/M; high range H/M, L/H, H/H, M/H.
- R7: The total spread, in units of 0.01 % and equal to 2·H, comes from the table for the code and band. Two examples: M/M in band 0 gives 430, so H = 215. H/H in band 12 gives 110, so H = 55.
- R8: If the code is not valid in the range of the band, the code is reserved, or the band is above 12, then for the whole period `cfg_err_o` is 1 and the offset is 0. The position keeps counting.
- R9: The select and band inputs are sampled only when a period is loaded. Changes made during a period have no effect until the next period starts.
- R10: `offset_o` is a 16-bit two's-complement value in units of 0.01 % of the nominal frequency. For example, −215 is 16'hFF29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spread_en_i | input | 1 | High enables spreading; low forces a zero offset |
| sel_a_i | input | 2 | First three-level select, decoded |
| sel_b_i | input | 2 | Second three-level select, decoded |
| band_i | input | 4 | Input-frequency band index (0..12) |
| offset_o | output | 16 | Signed frequency offset, units of 0.01 % |
| cfg_err_o | output | 1 | Latched selection is invalid |

## Verification
The bench changes the selection halfway through a period. A design that samples its inputs continuously would bend the ramp at that point, and the old amplitude would not reach its expected values. The bench drops the enable in the middle of a sweep and raises it again. A design that resumes where it stopped, instead of restarting at the lowest point, fails the next check. The bench also visits the exact peak at position 1166 and the wrap from 2331 to 0, where an off-by-one counter either stretches the period or repeats a point. It feeds codes that are valid only in the other range, the reserved code and an out-of-range band. A design that decodes these as valid would produce a nonzero offset or leave the error flag low.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned AMP_W  = 10;
  localparam int unsigned BAND_W = 4;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  // Total peak-to-peak spread in 0.01 % units; zero marks an invalid selection.
  function automatic logic [AMP_W-1:0] spread_total(input logic [SEL_W-1:0] a,
                                                    input logic [SEL_W-1:0] b,
                                                    input logic [BAND_W-1:0] band);
    logic [AMP_W-1:0] v;
    v = '0;
    case ({a, b})
      {LVL_MID, LVL_MID}: case (band)
        4'd0: v = AMP_W'(430); 4'd1: v = AMP_W'(400);
        4'd2: v = AMP_W'(380); 4'd3: v = AMP_W'(350);
        default: v = '0;
      endcase
      {LVL_MID, LVL_LOW}: case (band)
        4'd0: v = AMP_W'(390); 4'd1: v = AMP_W'(360);
        4'd2: v = AMP_W'(340); 4'd3: v = AMP_W'(310);
        default: v = '0;
      endcase
      {LVL_HIGH, LVL_LOW}: case (band)
        4'd0: v = AMP_W'(330); 4'd1: v = AMP_W'(310);
        4'd2: v = AMP_W'(290); 4'd3: v = AMP_W'(270);
        default: v = '0;
      endcase
      {LVL_LOW, LVL_LOW}: case (band)
        4'd0: v = AMP_W'(290); 4'd1: v = AMP_W'(260);
        4'd2: v = AMP_W'(250); 4'd3: v = AMP_W'(220);
        default: v = '0;
      endcase
      {LVL_LOW, LVL_MID}: case (band)
        4'd0: v = AMP_W'(270); 4'd1: v = AMP_W'(250);
        4'd2: v = AMP_W'(240); 4'd3: v = AMP_W'(210);
        default: v = '0;
      endcase
      {LVL_HIGH, LVL_MID}: case (band)
        4'd4:  v = AMP_W'(300); 4'd5:  v = AMP_W'(270); 4'd6:  v = AMP_W'(260);
        4'd7:  v = AMP_W'(260); 4'd8:  v = AMP_W'(250); 4'd9:  v = AMP_W'(240);
        4'd10: v = AMP_W'(240); 4'd11: v = AMP_W'(230); 4'd12: v = AMP_W'(230);
        default: v = '0;
      endcase
      {LVL_LOW, LVL_HIGH}: case (band)
        4'd4:  v = AMP_W'(240); 4'd5:  v = AMP_W'(210); 4'd6:  v = AMP_W'(200);
        4'd7:  v = AMP_W'(200); 4'd8:  v = AMP_W'(180); 4'd9:  v = AMP_W'(180);
        4'd10: v = AMP_W'(180); 4'd11: v = AMP_W'(170); 4'd12: v = AMP_W'(160);
        default: v = '0;
      endcase
      {LVL_HIGH, LVL_HIGH}: case (band)
        4'd4:  v = AMP_W'(160); 4'd5:  v = AMP_W'(140); 4'd6:  v = AMP_W'(130);
        4'd7:  v = AMP_W'(130); 4'd8:  v = AMP_W'(120); 4'd9:  v = AMP_W'(120);
        4'd10: v = AMP_W'(120); 4'd11: v = AMP_W'(110); 4'd12: v = AMP_W'(110);
        default: v = '0;
      endcase
      {LVL_MID, LVL_HIGH}: case (band)
        4'd4:  v = AMP_W'(130); 4'd5:  v = AMP_W'(110); 4'd6:  v = AMP_W'(110);
        4'd7:  v = AMP_W'(110); 4'd8:  v = AMP_W'(100); 4'd9:  v = AMP_W'(100);
        4'd10: v = AMP_W'(100); 4'd11: v = AMP_W'(90);  4'd12: v = AMP_W'(90);
        default: v = '0;
      endcase
      default: v = '0;
    endcase
    return v;
  endfunction

  // Triangle point: -half + floor(2*half*fold / half_len).
  function automatic logic signed [OFS_W-1:0] ramp_point(input int half,
                                                        input int fold,
                                                        input int half_len);
    int rise;
    rise = (2 * half * fold) / half_len;
    return OFS_W'(rise - half);
  endfunction
endpackage

// File: rtl/ssc_period_ctr.sv
module ssc_period_ctr #(
  parameter int unsigned PERIOD = 2332,
  parameter int unsigned PH_W   = $clog2(PERIOD)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  output logic            load_o,
  output logic [PH_W-1:0] phase_nxt_o,
  output logic [PH_W-1:0] phase_q_o,
  output logic            run_q_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase_q;
  logic            run_q;

  always_comb begin
    load_o = en_i && (!run_q || phase_q == LAST);
    if (!en_i || load_o) phase_nxt_o = '0;
    else                 phase_nxt_o = phase_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      run_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt_o;
      run_q   <= en_i;
    end
  end

  assign phase_q_o = phase_q;
  assign run_q_o   = run_q;

  a_r2_phase_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= LAST);
  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && run_q && phase_q == LAST) |=> (phase_q == '0));
  a_r5_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_q == '0 && !run_q));
endmodule

// File: rtl/ssc_sel_latch.sv
module ssc_sel_latch
  import ssc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [SEL_W-1:0]  sel_a_i,
  input  logic [SEL_W-1:0]  sel_b_i,
  input  logic [BAND_W-1:0] band_i,
  output logic [AMP_W-1:0]  half_nxt_o,
  output logic              err_nxt_o,
  output logic [AMP_W-1:0]  half_q_o,
  output logic              err_q_o
);
  logic [AMP_W-1:0] total;
  logic [AMP_W-1:0] half_q;
  logic             err_q;

  always_comb begin
    total = spread_total(sel_a_i, sel_b_i, band_i);
    if (load_i) begin
      half_nxt_o = total >> 1;
      err_nxt_o  = (total == '0);
    end else begin
      half_nxt_o = half_q;
      err_nxt_o  = en_i ? err_q : 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= '0;
      err_q  <= 1'b0;
    end else begin
      half_q <= half_nxt_o;
      err_q  <= err_nxt_o;
    end
  end

  assign half_q_o = half_q;
  assign err_q_o  = err_q;

  // R9: selection only moves on a period load
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !load_i) |=> ($stable(half_q) && $stable(err_q)));
  a_r5_err_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !err_q);
endmodule

// File: rtl/ssc_ramp_gen.sv
module ssc_ramp_gen
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD = 2332,
  parameter int unsigned PH_W   = $clog2(PERIOD)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    err_nxt_i,
  input  logic [AMP_W-1:0]        half_nxt_i,
  input  logic [PH_W-1:0]         phase_nxt_i,
  output logic signed [OFS_W-1:0] offset_q_o
);
  localparam int unsigned HALF_LEN = PERIOD / 2;

  logic [PH_W-1:0]         fold;
  logic signed [OFS_W-1:0] point;
  logic signed [OFS_W-1:0] offset_d;

  always_comb begin
    if (phase_nxt_i <= PH_W'(HALF_LEN)) fold = phase_nxt_i;
    else                                fold = PH_W'(PERIOD) - phase_nxt_i;
    point = ramp_point(int'(half_nxt_i), int'(fold), int'(HALF_LEN));
    if (!en_i || err_nxt_i) offset_d = '0;
    else                    offset_d = point;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) offset_q_o <= '0;
    else         offset_q_o <= offset_d;
  end

  a_r5_off_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (offset_q_o == '0));
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
#(
  parameter int unsigned PERIOD = 2332
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    spread_en_i,
  input  logic [1:0]              sel_a_i,
  input  logic [1:0]              sel_b_i,
  input  logic [3:0]              band_i,
  output logic signed [15:0]      offset_o,
  output logic                    cfg_err_o
);
  localparam int unsigned PH_W     = $clog2(PERIOD);
  localparam int unsigned HALF_LEN = PERIOD / 2;

  logic             load;
  logic [PH_W-1:0]  phase_nxt;
  logic [PH_W-1:0]  phase_q;
  logic             run_q;
  logic [AMP_W-1:0] half_nxt;
  logic             err_nxt;
  logic [AMP_W-1:0] half_q;
  logic             err_q;

  ssc_period_ctr #(.PERIOD(PERIOD), .PH_W(PH_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (spread_en_i),
    .load_o      (load),
    .phase_nxt_o (phase_nxt),
    .phase_q_o   (phase_q),
    .run_q_o     (run_q)
  );

  ssc_sel_latch u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (spread_en_i),
    .load_i     (load),
    .sel_a_i    (sel_a_i),
    .sel_b_i    (sel_b_i),
    .band_i     (band_i),
    .half_nxt_o (half_nxt),
    .err_nxt_o  (err_nxt),
    .half_q_o   (half_q),
    .err_q_o    (err_q)
  );

  ssc_ramp_gen #(.PERIOD(PERIOD), .PH_W(PH_W)) u_ramp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (spread_en_i),
    .err_nxt_i   (err_nxt),
    .half_nxt_i  (half_nxt),
    .phase_nxt_i (phase_nxt),
    .offset_q_o  (offset_o)
  );

  assign cfg_err_o = err_q;

  logic signed [OFS_W-1:0] half_s;
  logic                    sweeping;
  assign half_s   = {{(OFS_W-AMP_W){1'b0}}, half_q};
  assign sweeping = run_q && !err_q;

  a_r3_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweeping && phase_q == '0) |-> (offset_o == -half_s));
  a_r4_peak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweeping && phase_q == PH_W'(HALF_LEN)) |-> (offset_o == half_s));
  a_r4_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweeping |-> (offset_o <= half_s && offset_o >= -half_s));
  a_r8_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (offset_o == '0));
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (offset_o == '0 && !cfg_err_o));
endmodule

// File: tb/test_ssc_profile_gen.sv
`timescale 1ns/1ps
module test_ssc_profile_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [1:0] sa = 2'b01, sb = 2'b01;
  logic [3:0] band = 4'd0;
  logic signed [15:0] ofs;
  logic err;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ssc_profile_gen i_ssc_profile_gen (
    .clk_i(clk), .rst_ni(rst_n), .spread_en_i(en),
    .sel_a_i(sa), .sel_b_i(sb), .band_i(band),
    .offset_o(ofs), .cfg_err_o(err)
  );

  // Spread table per requirement R6/R7, rows in decreasing-spread order.
  localparam int LOW_T [5][4] = '{'{430,400,380,350}, '{390,360,340,310},
                                  '{330,310,290,270}, '{290,260,250,220},
                                  '{270,250,240,210}};
  localparam int HIGH_T [4][9] = '{'{300,270,260,260,250,240,240,230,230},
                                   '{240,210,200,200,180,180,180,170,160},
                                   '{160,140,130,130,120,120,120,110,110},
                                   '{130,110,110,110,100,100,100, 90, 90}};
  localparam logic [3:0] LOW_C  [5] = '{4'b0101, 4'b0100, 4'b1000, 4'b0000, 4'b0001};
  localparam logic [3:0] HIGH_C [4] = '{4'b1001, 4'b0010, 4'b1010, 4'b0110};

  function automatic int ref_total(logic [1:0] a, logic [1:0] b, logic [3:0] bd);
    if (bd <= 4'd3) begin
      for (int i = 0; i < 5; i++) if ({a, b} == LOW_C[i]) return LOW_T[i][bd];
    end else if (bd <= 4'd12) begin
      for (int i = 0; i < 4; i++) if ({a, b} == HIGH_C[i]) return HIGH_T[i][bd-4];
    end
    return -1;
  endfunction

  // Behavioural reference model
  int  m_cnt = 0, m_half = 0, exp_ofs = 0;
  bit  m_run = 0, m_err = 0, exp_err = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_half = 0; m_err = 0; exp_ofs = 0; exp_err = 0;
    end else if (!en) begin
      m_run = 0; m_cnt = 0; exp_ofs = 0; exp_err = 0; m_err = 0;
    end else begin
      int tot, q;
      if (!m_run || m_cnt == 2331) begin
        m_cnt = 0;
        tot = ref_total(sa, sb, band);
        m_err = (tot < 0);
        m_half = m_err ? 0 : tot / 2;
        m_run = 1;
      end else m_cnt++;
      q = (m_cnt <= 1166) ? m_cnt : 2332 - m_cnt;
      exp_ofs = m_err ? 0 : (2 * m_half * q) / 1166 - m_half;
      exp_err = m_err;
    end
  end

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n && !done) begin
      string tag;
      tag = exp_err ? "R8" : (!m_run ? "R5" : "R3");
      chk(tag, int'(ofs), exp_ofs);
      chk("R8 flag", int'(err), int'(exp_err));
    end
  end

  task automatic restart();
    en = 1'b0; @(negedge clk);
    en = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ofs", int'(ofs), 0);
    chk("R1 reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ofs", int'(ofs), 0);
    cmp_on = 1;

    // M/M band 0: H = 215
    en = 1'b1; @(negedge clk);
    chk("R7 MM min", int'(ofs), -215);
    chk("R10 encoding", int'(ofs[15:0]), int'(16'hFF29));
    repeat (1166) @(negedge clk);
    chk("R4 MM peak", int'(ofs), 215);
    // change selection mid-period: H/H band 12
    sa = 2'b10; sb = 2'b10; band = 4'd12;
    repeat (583) @(negedge clk);
    chk("R9 old amplitude kept", int'(ofs), 0);
    repeat (583) @(negedge clk);
    chk("R2 new period at min", int'(ofs), -55);
    repeat (1166) @(negedge clk);
    chk("R7 HH peak", int'(ofs), 55);

    // disable mid-sweep
    repeat (300) @(negedge clk);
    en = 1'b0; @(negedge clk);
    chk("R5 off zero", int'(ofs), 0);
    repeat (5) @(negedge clk);
    chk("R5 still zero", int'(ofs), 0);
    en = 1'b1; @(negedge clk);
    chk("R5 restart at min", int'(ofs), -55);
    repeat (10) @(negedge clk);

    // invalid selections
    sa = 2'b10; sb = 2'b10; band = 4'd2;
    restart();
    chk("R8 cross-range err", int'(err), 1);
    chk("R8 cross-range ofs", int'(ofs), 0);
    sa = 2'b01; sb = 2'b01; band = 4'd0;
    repeat (100) @(negedge clk);
    chk("R8 err held in period", int'(err), 1);
    sa = 2'b11; sb = 2'b01;
    restart();
    chk("R8 reserved code", int'(err), 1);
    sa = 2'b01; sb = 2'b01; band = 4'd13;
    restart();
    chk("R8 band 13", int'(err), 1);
    repeat (50) @(negedge clk);

    // L/M band 3: smallest low-range spread
    sa = 2'b00; sb = 2'b01; band = 4'd3;
    restart();
    chk("R6 LM err", int'(err), 0);
    chk("R6 LM min", int'(ofs), -105);

    // every valid code for a full period, checked by the model
    for (int i = 0; i < 5; i++) begin
      {sa, sb} = LOW_C[i]; band = 4'(i % 4);
      restart();
      chk("R6 low code min", int'(ofs), -(LOW_T[i][i % 4] / 2));
      repeat (2332) @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      {sa, sb} = HIGH_C[i]; band = 4'(4 + 2 * i);
      restart();
      chk("R6 high code min", int'(ofs), -(HIGH_T[i][2 * i] / 2));
      repeat (2332) @(negedge clk);
    end

    finish_run();
  end
endmodule